// File: doc/BRIEF.md
# Per-Monitor Privilege Trap Controller

This block holds one 64-bit policy register that governs how the lower privilege levels (0, 1 and 2) may touch the system registers of up to 32 system performance monitors. Each monitor owns a 2-bit policy field. The field can send both reads and writes to the top level (level 3), send only writes there, or let every access through. Only level 3 may read or write the policy register itself. Every attempt to reach it from a lower level, and every attempt when the monitor feature is configured out, is reported as an undefined instruction.

An upstream decoder presents one decoded system-register access per cycle. The access carries its encoding fields, its direction, the current level, the target monitor index and a flag saying whether the target lies in the monitor register group. A flag for a higher-priority exception raised by the same instruction comes with it. One clock later the block returns a registered response: a valid strobe, the read data, an undefined flag and a trap flag. A policy write made by level 3 takes effect on the edge that registers its response, so the next access already sees the new policy.

Top module: `pmu_trap_ctrl`

## Requirements
- R1: After reset the policy register is all zeros and every response output is 0. As a result, any monitor-group access from levels 0 to 2 traps until level 3 changes the policy.
- R2: A level-3 access whose encoding is op0=2'b10, op1=3'b110, CRn=4'b1001, CRm=4'b1101, op2=3'b011 reaches the policy register. A write stores req_wdata_i. A read returns the stored value on rsp_rdata_o one cycle later. Neither raises undef or trap.
- R3: An access to the policy-register encoding from level 0, 1 or 2 raises rsp_undef_o, returns zero read data, never raises rsp_trap_o and leaves the register unchanged.
- R4: A monitor-group access from levels 0 to 2 traps for both reads and writes when the monitor's field is 2'b00 or the reserved value 2'b10.
- R5: With field 2'b01, monitor-group writes from levels 0 to 2 trap and reads do not.
- R6: With field 2'b11, no monitor-group access traps.
- R7: A monitor-group access made from level 3 never traps, whatever the field holds.
- R8: When hi_prio_exc_i is set with an access, rsp_trap_o stays 0 for that access.
- R9: With the feature parameter FEAT_EN set to 0, every access to the policy-register encoding raises rsp_undef_o at every level, including level 3. The register then keeps its reset value.
- R10: rsp_valid_o equals req_valid_i of the previous cycle. An access that is neither a policy-register access nor in the monitor group yields undef 0, trap 0 and read data 0. Outputs are all zero when rsp_valid_o is 0.
- R11: The field for monitor m sits at register bits [2m+1:2m], and req_mon_idx_i selects m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access present this cycle |
| req_write_i | input | 1 | 1 = register write, 0 = register read |
| req_el_i | input | 2 | Current privilege level, 0 to 3 |
| req_op0_i | input | 2 | Encoding field op0 |
| req_op1_i | input | 3 | Encoding field op1 |
| req_crn_i | input | 4 | Encoding field CRn |
| req_crm_i | input | 4 | Encoding field CRm |
| req_op2_i | input | 3 | Encoding field op2 |
| req_mon_grp_i | input | 1 | Target is a monitor-group register |
| req_mon_idx_i | input | 5 | Index of the targeted monitor |
| req_wdata_i | input | 64 | Write data for the policy register |
| hi_prio_exc_i | input | 1 | Same instruction raises a higher-priority exception |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the access |
| rsp_rdata_o | output | 64 | Policy-register read data |
| rsp_undef_o | output | 1 | Access is an undefined instruction |
| rsp_trap_o | output | 1 | Access traps to level 3 |

## Verification
The assertions assume that the request inputs are stable and known whenever req_valid_i is high. They also assume that req_valid_i stays low while reset is held, because the strobe relation looks one cycle back. They assume that req_mon_idx_i names a monitor that exists. The bench holds valid low through reset and draws every index modulo the monitor count. It drives all inputs on the falling edge, so nothing changes near a sampling edge. Roughly a quarter of the random accesses use the exact policy-register encoding, so writes from level 3 keep changing the policy that the random monitor accesses then exercise.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    localparam int unsigned MON_CNT = 32;
    localparam int unsigned FLD_W   = 2;
    localparam int unsigned REG_W   = MON_CNT * FLD_W;

    // Encoding of the policy register
    localparam logic [1:0] SEL_OP0 = 2'b10;
    localparam logic [2:0] SEL_OP1 = 3'b110;
    localparam logic [3:0] SEL_CRN = 4'b1001;
    localparam logic [3:0] SEL_CRM = 4'b1101;
    localparam logic [2:0] SEL_OP2 = 3'b011;

    localparam logic [1:0] LVL_TOP = 2'd3;

    typedef enum logic [1:0] {
        POL_BLOCK_ALL = 2'b00,
        POL_BLOCK_WR  = 2'b01,
        POL_RESERVED  = 2'b10,
        POL_OPEN      = 2'b11
    } pol_e;
endpackage

// File: rtl/ptc_sel_decode.sv
module ptc_sel_decode #(
    parameter bit FEAT_EN = 1'b1
) (
    input  logic [1:0] op0_i,
    input  logic [2:0] op1_i,
    input  logic [3:0] crn_i,
    input  logic [3:0] crm_i,
    input  logic [2:0] op2_i,
    input  logic [1:0] el_i,
    output logic       hit_o,
    output logic       grant_o,
    output logic       undef_o
);
    import ptc_pkg::*;

    always_comb begin
        hit_o   = (op0_i == SEL_OP0) && (op1_i == SEL_OP1) && (crn_i == SEL_CRN)
               && (crm_i == SEL_CRM) && (op2_i == SEL_OP2);
        grant_o = hit_o && FEAT_EN && (el_i == LVL_TOP);
        undef_o = hit_o && !grant_o;
    end
endmodule

// File: rtl/ptc_policy_reg.sv
module ptc_policy_reg #(
    parameter int unsigned NUM_MON = ptc_pkg::MON_CNT,
    parameter int unsigned FLD_W   = ptc_pkg::FLD_W,
    localparam int unsigned REG_W  = NUM_MON * FLD_W
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [REG_W-1:0]               wdata_i,
    output logic [REG_W-1:0]               reg_o,
    output logic [NUM_MON-1:0][FLD_W-1:0]  fld_o
);
    logic [REG_W-1:0] pol_d, pol_q;

    always_comb begin
        pol_d = pol_q;
        if (wr_en_i) begin
            pol_d = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pol_q <= '0;
        end else begin
            pol_q <= pol_d;
        end
    end

    assign reg_o = pol_q;

    for (genvar m = 0; m < NUM_MON; m++) begin : g_fld
        assign fld_o[m] = pol_q[m*FLD_W +: FLD_W];
    end
endmodule

// File: rtl/ptc_trap_decide.sv
module ptc_trap_decide (
    input  logic [1:0] pol_i,
    input  logic       mon_acc_i,
    input  logic       write_i,
    input  logic [1:0] el_i,
    input  logic       hi_prio_i,
    output logic       trap_o
);
    import ptc_pkg::*;

    logic blocked;

    always_comb begin
        unique case (pol_e'(pol_i))
            POL_BLOCK_ALL: blocked = 1'b1;
            POL_RESERVED:  blocked = 1'b1;
            POL_BLOCK_WR:  blocked = write_i;
            POL_OPEN:      blocked = 1'b0;
            default:       blocked = 1'b1;
        endcase
        trap_o = mon_acc_i && (el_i != LVL_TOP) && !hi_prio_i && blocked;
    end
endmodule

// File: rtl/pmu_trap_ctrl.sv
module pmu_trap_ctrl #(
    parameter bit          FEAT_EN = 1'b1,
    parameter int unsigned NUM_MON = ptc_pkg::MON_CNT,
    localparam int unsigned FLD_W  = ptc_pkg::FLD_W,
    localparam int unsigned REG_W  = NUM_MON * FLD_W,
    localparam int unsigned IDX_W  = (NUM_MON > 1) ? $clog2(NUM_MON) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [1:0]       req_el_i,
    input  logic [1:0]       req_op0_i,
    input  logic [2:0]       req_op1_i,
    input  logic [3:0]       req_crn_i,
    input  logic [3:0]       req_crm_i,
    input  logic [2:0]       req_op2_i,
    input  logic             req_mon_grp_i,
    input  logic [IDX_W-1:0] req_mon_idx_i,
    input  logic [REG_W-1:0] req_wdata_i,
    input  logic             hi_prio_exc_i,
    output logic             rsp_valid_o,
    output logic [REG_W-1:0] rsp_rdata_o,
    output logic             rsp_undef_o,
    output logic             rsp_trap_o
);
    typedef struct packed {
        logic             vld;
        logic             undef;
        logic             trap;
        logic [REG_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic                          sel_hit, sel_grant, sel_undef;
    logic                          wr_en, mon_acc, trap_raw;
    logic [REG_W-1:0]              pol_reg;
    logic [NUM_MON-1:0][FLD_W-1:0] pol_fld;
    logic [FLD_W-1:0]              pol_sel;

    ptc_sel_decode #(.FEAT_EN(FEAT_EN)) u_dec (
        .op0_i   (req_op0_i),
        .op1_i   (req_op1_i),
        .crn_i   (req_crn_i),
        .crm_i   (req_crm_i),
        .op2_i   (req_op2_i),
        .el_i    (req_el_i),
        .hit_o   (sel_hit),
        .grant_o (sel_grant),
        .undef_o (sel_undef)
    );

    assign wr_en = req_valid_i && sel_grant && req_write_i;

    ptc_policy_reg #(.NUM_MON(NUM_MON), .FLD_W(FLD_W)) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en),
        .wdata_i (req_wdata_i),
        .reg_o   (pol_reg),
        .fld_o   (pol_fld)
    );

    assign pol_sel = pol_fld[req_mon_idx_i];
    assign mon_acc = req_mon_grp_i && !sel_hit;

    ptc_trap_decide u_dcd (
        .pol_i     (pol_sel),
        .mon_acc_i (mon_acc),
        .write_i   (req_write_i),
        .el_i      (req_el_i),
        .hi_prio_i (hi_prio_exc_i),
        .trap_o    (trap_raw)
    );

    always_comb begin
        rsp_d     = '0;
        rsp_d.vld = req_valid_i;
        if (req_valid_i) begin
            if (sel_grant) begin
                if (!req_write_i) begin
                    rsp_d.rdata = pol_reg;
                end
            end else if (sel_undef) begin
                rsp_d.undef = 1'b1;
            end else begin
                rsp_d.trap = trap_raw;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.vld;
    assign rsp_rdata_o = rsp_q.rdata;
    assign rsp_undef_o = rsp_q.undef;
    assign rsp_trap_o  = rsp_q.trap;
endmodule

// File: rtl/ptc_chk.sv
module ptc_chk #(
    parameter int unsigned REG_W = ptc_pkg::REG_W
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             req_valid_i,
    input logic [1:0]       req_el_i,
    input logic [1:0]       req_op0_i,
    input logic [2:0]       req_op1_i,
    input logic [3:0]       req_crn_i,
    input logic [3:0]       req_crm_i,
    input logic [2:0]       req_op2_i,
    input logic             hi_prio_exc_i,
    input logic             rsp_valid_o,
    input logic [REG_W-1:0] rsp_rdata_o,
    input logic             rsp_undef_o,
    input logic             rsp_trap_o
);
    import ptc_pkg::*;

    logic enc_hit;
    assign enc_hit = (req_op0_i == SEL_OP0) && (req_op1_i == SEL_OP1) && (req_crn_i == SEL_CRN)
                  && (req_crm_i == SEL_CRM) && (req_op2_i == SEL_OP2);

    // R10
    strobe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    // R10
    strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o);

    // R10
    quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rsp_valid_o |-> (!rsp_undef_o && !rsp_trap_o && rsp_rdata_o == '0));

    // R8
    hi_prio_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && hi_prio_exc_i) |=> !rsp_trap_o);

    // R7
    top_level_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_el_i == LVL_TOP && !enc_hit) |=> !rsp_trap_o);

    // R3
    low_level_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_el_i != LVL_TOP && enc_hit) |=> (rsp_undef_o && !rsp_trap_o));

    // R3
    undef_trap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rsp_undef_o && rsp_trap_o));
endmodule

bind pmu_trap_ctrl ptc_chk #(.REG_W(REG_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_el_i      (req_el_i),
    .req_op0_i     (req_op0_i),
    .req_op1_i     (req_op1_i),
    .req_crn_i     (req_crn_i),
    .req_crm_i     (req_crm_i),
    .req_op2_i     (req_op2_i),
    .hi_prio_exc_i (hi_prio_exc_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .rsp_undef_o   (rsp_undef_o),
    .rsp_trap_o    (rsp_trap_o)
);

// File: tb/sim_pmu_trap_ctrl.sv
`timescale 1ns/1ps
module sim_pmu_trap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0, wr = 1'b0, hp = 1'b0, grp = 1'b0;
    logic [1:0]  el = '0, op0 = '0;
    logic [2:0]  op1 = '0, op2 = '0;
    logic [3:0]  crn = '0, crm = '0;
    logic [4:0]  idx = '0;
    logic [63:0] wdata = '0;

    logic        v0, u0_undef, u0_trap, v1, u1_undef, u1_trap;
    logic [63:0] rd0, rd1;

    int unsigned n_chk = 0, n_fail = 0;
    logic [63:0] mirror = '0;

    always #2 clk = ~clk;

    pmu_trap_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(wr), .req_el_i(el),
        .req_op0_i(op0), .req_op1_i(op1), .req_crn_i(crn), .req_crm_i(crm), .req_op2_i(op2),
        .req_mon_grp_i(grp), .req_mon_idx_i(idx), .req_wdata_i(wdata), .hi_prio_exc_i(hp),
        .rsp_valid_o(v0), .rsp_rdata_o(rd0), .rsp_undef_o(u0_undef), .rsp_trap_o(u0_trap)
    );

    pmu_trap_ctrl #(.FEAT_EN(1'b0)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(wr), .req_el_i(el),
        .req_op0_i(op0), .req_op1_i(op1), .req_crn_i(crn), .req_crm_i(crm), .req_op2_i(op2),
        .req_mon_grp_i(grp), .req_mon_idx_i(idx), .req_wdata_i(wdata), .hi_prio_exc_i(hp),
        .rsp_valid_o(v1), .rsp_rdata_o(rd1), .rsp_undef_o(u1_undef), .rsp_trap_o(u1_trap)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected {undef, trap, rdata} from the requirements
    function automatic logic [65:0] predict(input logic [63:0] r, input bit feat, input logic [1:0] lv,
                                            input bit w, input bit g, input int m, input bit h,
                                            input bit hit);
        logic [1:0] f;
        bit t;
        f = r[2*m +: 2];
        if (hit) begin
            if (feat && lv == 2'd3) return {2'b00, (w ? 64'd0 : r)};
            return {2'b10, 64'd0};
        end
        t = 1'b0;
        if (g && lv != 2'd3 && !h) begin
            if (f == 2'b11)      t = 1'b0;
            else if (f == 2'b01) t = w;
            else                 t = 1'b1;
        end
        return {1'b0, t, 64'd0};
    endfunction

    task automatic txn(input string req, input logic [1:0] lv, input bit w, input bit sel,
                       input bit g, input int m, input bit h, input logic [63:0] d);
        logic [65:0] e0, e1;
        bit hit;
        valid = 1'b1; wr = w; el = lv; grp = g; idx = m[4:0]; hp = h; wdata = d;
        if (sel) begin
            op0 = 2'b10; op1 = 3'b110; crn = 4'b1001; crm = 4'b1101; op2 = 3'b011;
        end else begin
            op0 = 2'($urandom); op1 = 3'($urandom); crn = 4'($urandom);
            crm = 4'($urandom); op2 = 3'($urandom);
        end
        hit = (op0 == 2'b10) && (op1 == 3'b110) && (crn == 4'b1001) && (crm == 4'b1101) && (op2 == 3'b011);
        e0 = predict(mirror, 1'b1, lv, w, g, m, h, hit);
        e1 = predict(64'd0, 1'b0, lv, w, g, m, h, hit);
        if (hit && lv == 2'd3 && w) mirror = d;
        @(negedge clk);
        check({req, " valid"}, 64'(v0), 64'd1);
        check({req, " undef"}, 64'(u0_undef), 64'(e0[65]));
        check({req, " trap"},  64'(u0_trap),  64'(e0[64]));
        check({req, " rdata"}, rd0, e0[63:0]);
        check("R9 undef (feature off)", 64'(u1_undef), 64'(e1[65]));
        check("R9 trap (feature off)",  64'(u1_trap),  64'(e1[64]));
        check("R9 rdata (feature off)", rd1, e1[63:0]);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] pat;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid after reset", 64'(v0), 64'd0);
        check("R1 undef after reset", 64'(u0_undef), 64'd0);
        check("R1 trap after reset", 64'(u0_trap), 64'd0);
        check("R1 rdata after reset", rd0, 64'd0);
        txn("R1 fresh read traps", 2'd0, 1'b0, 1'b0, 1'b1, 5, 1'b0, '0);
        txn("R1 register reads zero", 2'd3, 1'b0, 1'b1, 1'b0, 0, 1'b0, '0);

        // R11 field layout: m0=00, m7=01, m9=11, m12=10, m31=11
        pat = '0;
        pat[15:14] = 2'b01; pat[19:18] = 2'b11; pat[25:24] = 2'b10; pat[63:62] = 2'b11;
        txn("R2 top write", 2'd3, 1'b1, 1'b1, 1'b0, 0, 1'b0, pat);
        txn("R2 top read back", 2'd3, 1'b0, 1'b1, 1'b0, 0, 1'b0, '0);
        check("R2 read value", rd0, pat);
        txn("R5 read open", 2'd1, 1'b0, 1'b0, 1'b1, 7, 1'b0, '0);
        txn("R5 write traps", 2'd1, 1'b1, 1'b0, 1'b1, 7, 1'b0, '0);
        txn("R6 read open", 2'd2, 1'b0, 1'b0, 1'b1, 9, 1'b0, '0);
        txn("R6 write open", 2'd0, 1'b1, 1'b0, 1'b1, 9, 1'b0, '0);
        txn("R11 top field m31", 2'd2, 1'b1, 1'b0, 1'b1, 31, 1'b0, '0);
        txn("R4 reserved read", 2'd1, 1'b0, 1'b0, 1'b1, 12, 1'b0, '0);
        txn("R4 zero write", 2'd2, 1'b1, 1'b0, 1'b1, 0, 1'b0, '0);
        txn("R7 top never traps", 2'd3, 1'b1, 1'b0, 1'b1, 0, 1'b0, '0);
        txn("R8 higher priority", 2'd0, 1'b1, 1'b0, 1'b1, 0, 1'b1, '0);
        txn("R3 low write undef", 2'd2, 1'b1, 1'b1, 1'b0, 0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        txn("R3 low read undef", 2'd0, 1'b0, 1'b1, 1'b0, 0, 1'b0, '0);
        txn("R3 register unchanged", 2'd3, 1'b0, 1'b1, 1'b0, 0, 1'b0, '0);
        txn("R10 unrelated access", 2'd1, 1'b1, 1'b0, 1'b0, 3, 1'b0, '0);
        valid = 1'b0;
        @(negedge clk);
        check("R10 idle strobe", 64'(v0), 64'd0);
        check("R10 idle trap", 64'(u0_trap), 64'd0);

        for (int i = 0; i < 600; i++) begin
            int k;
            k = int'($urandom % 8);
            txn((k < 2) ? "R2 R3 random register" : ((k < 6) ? "R4 R5 R6 random monitor" : "R10 random other"),
                2'($urandom), 1'($urandom), (k < 2), (k >= 2 && k < 6),
                int'($urandom % 32), ($urandom % 5 == 0), {$urandom, $urandom});
        end
        valid = 1'b0;
        @(negedge clk);
        summary();
        $finish;
    end
endmodule